// File: doc/BRIEF.md
# GCI Frame Time-Slot Interface

This block is the serial line end of a GCI-style subscriber bus. A line clock running at twice the bit rate, a frame sync pulse and one receive and one transmit data wire carry a 32-bit frame every frame period. Within a frame, two 8-bit bearer channels come first, then an 8-bit monitor channel, a 2-bit signaling channel, a 4-bit command/indicate field and two single-bit flags (A, then E). Received frames are split into these fields, latched once per frame and announced by a one-cycle strobe. On transmit, the same fields are serialized from a snapshot taken at frame start.

A 32-bit enable map, one bit per frame position, picks which positions the block takes part in. This allows rate adaptation down to a single bit per frame. On a position that is not enabled, the transmitter releases the line: the drive enable falls and the data output rests high, matching an external pull-up. The receiver stores 0 for such a position.

Framing starts at the first sync after reset. After that the counter runs on by itself, so further syncs may be sent or left out. A sync that arrives anywhere other than the frame boundary restarts framing and sets a sticky error flag.

Top module: `gci_slot_if`

## Requirements
- R1: Each frame position occupies CLK_PER_BIT (default 2) clock cycles. The transmit data stays constant across both cycles of a position. With sync_i high at a clock edge, the cycle that follows is position 0.
- R2: Frame position p carries bit 31-p of the vector {b1, b2, mon, d, ci, a, e}. Each field goes most significant bit first: B1 at positions 0-7, B2 at 8-15, monitor at 16-23, D at 24-25, C/I at 26-29, A at 30 and E at 31.
- R3: rxd_i is sampled in the last clock cycle of each position. en_map_i[p] = 1 stores the sampled value for position p; en_map_i[p] = 0 stores 0.
- R4: rx_valid_o is high for exactly the one cycle after the edge that samples position 31. At that edge the rx field outputs update, and they hold their values until the next such edge.
- R5: txd_oe_o is 1 only while framing is running and en_map_i is 1 at the current position. In that case txd_o is the field bit for that position. Otherwise txd_oe_o is 0 and txd_o is 1.
- R6: The tx field inputs are captured at the edge that starts a frame, whether a sync or the wrap from position 31. A change made later in the frame first shows on the line in the following frame.
- R7: Until the first sync after reset, the block never drives the line, never strobes rx_valid_o and never flags an error.
- R8: A sync that is not at the edge ending position 31's last cycle restarts framing at position 0 and sets sync_err_o. sync_err_o stays high until reset. The cut-short frame produces no rx_valid_o strobe.
- R9: A sync at the frame boundary raises no error. Without sync, framing wraps from position 31 to position 0 on its own every 32 positions.
- R10: During reset, txd_oe_o=0, txd_o=1, rx_valid_o=0, sync_err_o=0 and all rx fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync; the cycle after it is position 0 |
| rxd_i | input | 1 | Serial receive data |
| en_map_i | input | 32 | Per-position enable, bit p for position p |
| tx_b1_i | input | 8 | First bearer field to send |
| tx_b2_i | input | 8 | Second bearer field to send |
| tx_mon_i | input | 8 | Monitor field to send |
| tx_d_i | input | 2 | Signaling field to send |
| tx_ci_i | input | 4 | Command/indicate field to send |
| tx_a_i | input | 1 | A flag to send |
| tx_e_i | input | 1 | E flag to send |
| txd_o | output | 1 | Serial transmit data, 1 when released |
| txd_oe_o | output | 1 | Transmit drive enable |
| rx_b1_o | output | 8 | Received first bearer field |
| rx_b2_o | output | 8 | Received second bearer field |
| rx_mon_o | output | 8 | Received monitor field |
| rx_d_o | output | 2 | Received signaling field |
| rx_ci_o | output | 4 | Received command/indicate field |
| rx_a_o | output | 1 | Received A flag |
| rx_e_o | output | 1 | Received E flag |
| rx_valid_o | output | 1 | One-cycle strobe when a new frame is latched |
| sync_err_o | output | 1 | Sticky misplaced-sync flag |

## Verification
The bench builds the block with its default parameters: two clocks per bit and the 8/8/8/2/4/1/1 field split, which gives a 64-cycle frame. At that size, each frame walks through every position and every field edge, including the single-bit A and E slots and the 2-bit signaling field, within a few dozen cycles. This lets the bench cover all-enabled, signaling-only, single-bit and random enable maps, mid-frame tx field updates, free-running frames without sync and a misplaced sync, all in a few hundred cycles.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int unsigned B_W     = 8;
  localparam int unsigned MON_W   = 8;
  localparam int unsigned D_W     = 2;
  localparam int unsigned CI_W    = 4;
  localparam int unsigned FRAME_W = 2 * B_W + MON_W + D_W + CI_W + 2;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  // packed MSB is sent first on the line
  typedef struct packed {
    logic [B_W-1:0]   b1;
    logic [B_W-1:0]   b2;
    logic [MON_W-1:0] mon;
    logic [D_W-1:0]   d;
    logic [CI_W-1:0]  ci;
    logic             a;
    logic             e;
  } gci_frame_t;
endpackage

// File: rtl/gci_frame_cnt.sv
module gci_frame_cnt #(
  parameter int unsigned FRAME_W     = 32,
  parameter int unsigned CLK_PER_BIT = 2,
  localparam int unsigned BIT_W      = $clog2(FRAME_W),
  localparam int unsigned PH_W       = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic [PH_W-1:0]  phase_o,
  output logic             locked_o,
  output logic             sample_o,
  output logic             frame_end_o,
  output logic             frame_load_o,
  output logic             sync_err_o
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [BIT_W-1:0] bit_q;
  logic [PH_W-1:0]  ph_q;
  logic             locked_q, err_q;
  logic             last_ph, wrap;

  assign last_ph = (ph_q == PH_LAST);
  assign wrap    = last_ph && (bit_q == BIT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q    <= '0;
      ph_q     <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else if (sync_i) begin
      bit_q    <= '0;
      ph_q     <= '0;
      locked_q <= 1'b1;
      if (locked_q && !wrap) err_q <= 1'b1;
    end else if (locked_q) begin
      if (last_ph) begin
        ph_q  <= '0;
        bit_q <= wrap ? '0 : bit_q + 1'b1;
      end else begin
        ph_q  <= ph_q + 1'b1;
      end
    end
  end

  assign bit_idx_o    = bit_q;
  assign phase_o      = ph_q;
  assign locked_o     = locked_q;
  assign sample_o     = locked_q && last_ph;
  assign frame_end_o  = locked_q && wrap;
  assign frame_load_o = sync_i || (locked_q && wrap);
  assign sync_err_o   = err_q;
endmodule

// File: rtl/gci_rx_deframer.sv
module gci_rx_deframer #(
  parameter int unsigned FRAME_W = 32,
  localparam int unsigned BIT_W  = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sample_i,
  input  logic               frame_end_i,
  input  logic [BIT_W-1:0]   bit_idx_i,
  input  logic               en_bit_i,
  input  logic               rxd_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               valid_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] work_q, work_d, frame_q;
  logic               valid_q;
  logic [BIT_W-1:0]   slot;

  assign slot = BIT_LAST - bit_idx_i;

  always_comb begin
    work_d = work_q;
    if (sample_i) work_d[slot] = en_bit_i & rxd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q  <= '0;
      frame_q <= '0;
      valid_q <= 1'b0;
    end else begin
      work_q  <= work_d;
      valid_q <= frame_end_i;
      if (frame_end_i) frame_q <= work_d;
    end
  end

  assign frame_o = frame_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/gci_tx_framer.sv
module gci_tx_framer #(
  parameter int unsigned FRAME_W = 32,
  localparam int unsigned BIT_W  = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] fields_i,
  input  logic [BIT_W-1:0]   bit_idx_i,
  input  logic               active_i,
  output logic               txd_o,
  output logic               oe_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     shadow_q <= '0;
    else if (load_i) shadow_q <= fields_i;
  end

  // released positions rest at the pull-up level
  assign oe_o  = active_i;
  assign txd_o = active_i ? shadow_q[BIT_LAST - bit_idx_i] : 1'b1;
endmodule

// File: rtl/gci_slot_if.sv
module gci_slot_if
  import gci_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  input  logic               rxd_i,
  input  logic [FRAME_W-1:0] en_map_i,
  input  logic [B_W-1:0]     tx_b1_i,
  input  logic [B_W-1:0]     tx_b2_i,
  input  logic [MON_W-1:0]   tx_mon_i,
  input  logic [D_W-1:0]     tx_d_i,
  input  logic [CI_W-1:0]    tx_ci_i,
  input  logic               tx_a_i,
  input  logic               tx_e_i,
  output logic               txd_o,
  output logic               txd_oe_o,
  output logic [B_W-1:0]     rx_b1_o,
  output logic [B_W-1:0]     rx_b2_o,
  output logic [MON_W-1:0]   rx_mon_o,
  output logic [D_W-1:0]     rx_d_o,
  output logic [CI_W-1:0]    rx_ci_o,
  output logic               rx_a_o,
  output logic               rx_e_o,
  output logic               rx_valid_o,
  output logic               sync_err_o
);
  localparam int unsigned PH_W = (CLK_PER_BIT > 1) ? $clog2(CLK_PER_BIT) : 1;

  logic [BIT_W-1:0] bit_idx;
  logic [PH_W-1:0]  phase;
  logic             locked, sample, frame_end, frame_load;
  logic             en_cur, mid_bit;
  gci_frame_t       tx_frame, rx_frame;

  assign tx_frame = '{b1: tx_b1_i, b2: tx_b2_i, mon: tx_mon_i, d: tx_d_i,
                      ci: tx_ci_i, a: tx_a_i, e: tx_e_i};
  assign en_cur   = en_map_i[bit_idx];
  assign mid_bit  = (phase != '0);

  gci_frame_cnt #(.FRAME_W(FRAME_W), .CLK_PER_BIT(CLK_PER_BIT)) u_cnt (
    .clk_i, .rst_ni, .sync_i,
    .bit_idx_o(bit_idx), .phase_o(phase), .locked_o(locked),
    .sample_o(sample), .frame_end_o(frame_end), .frame_load_o(frame_load),
    .sync_err_o(sync_err_o)
  );

  gci_rx_deframer #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i, .rst_ni,
    .sample_i(sample), .frame_end_i(frame_end), .bit_idx_i(bit_idx),
    .en_bit_i(en_cur), .rxd_i,
    .frame_o(rx_frame), .valid_o(rx_valid_o)
  );

  gci_tx_framer #(.FRAME_W(FRAME_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i(frame_load), .fields_i(tx_frame), .bit_idx_i(bit_idx),
    .active_i(locked && en_cur),
    .txd_o(txd_o), .oe_o(txd_oe_o)
  );

  assign rx_b1_o  = rx_frame.b1;
  assign rx_b2_o  = rx_frame.b2;
  assign rx_mon_o = rx_frame.mon;
  assign rx_d_o   = rx_frame.d;
  assign rx_ci_o  = rx_frame.ci;
  assign rx_a_o   = rx_frame.a;
  assign rx_e_o   = rx_frame.e;
endmodule

// File: rtl/gci_slot_if_chk.sv
module gci_slot_if_chk
  import gci_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic [FRAME_W-1:0] en_map_i,
  input logic               txd_o,
  input logic               txd_oe_o,
  input logic               rx_valid_o,
  input logic               sync_err_o,
  input logic [BIT_W-1:0]   bit_idx,
  input logic               mid_bit,
  input logic               locked
);
  assert_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (bit_idx == '0 && !mid_bit));

  assert_bit_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_bit && txd_oe_o && $past(txd_oe_o)) |-> $stable(txd_o));

  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  assert_drive_enabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txd_oe_o |-> en_map_i[bit_idx]);

  assert_release_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !txd_oe_o |-> txd_o);

  assert_quiet_unlocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (!txd_oe_o && !rx_valid_o && !sync_err_o));

  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |=> sync_err_o);
endmodule

bind gci_slot_if gci_slot_if_chk u_chk (
  .clk_i, .rst_ni, .sync_i, .en_map_i, .txd_o, .txd_oe_o,
  .rx_valid_o, .sync_err_o, .bit_idx, .mid_bit, .locked
);

// File: tb/sim_gci_slot_if.sv
module sim_gci_slot_if;
  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, rxd = 1'b1;
  logic [31:0] en = '0;
  logic [7:0] tb1 = '0, tb2 = '0, tmon = '0;
  logic [1:0] td = '0;
  logic [3:0] tci = '0;
  logic ta = 1'b0, te = 1'b0;
  logic txd, txd_oe, rxv, serr;
  logic [7:0] rb1, rb2, rmon;
  logic [1:0] rd;
  logic [3:0] rci;
  logic ra, re;

  always #4 clk = ~clk;

  gci_slot_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .rxd_i(rxd), .en_map_i(en),
    .tx_b1_i(tb1), .tx_b2_i(tb2), .tx_mon_i(tmon), .tx_d_i(td), .tx_ci_i(tci),
    .tx_a_i(ta), .tx_e_i(te),
    .txd_o(txd), .txd_oe_o(txd_oe),
    .rx_b1_o(rb1), .rx_b2_o(rb2), .rx_mon_o(rmon), .rx_d_o(rd), .rx_ci_o(rci),
    .rx_a_o(ra), .rx_e_o(re), .rx_valid_o(rxv), .sync_err_o(serr)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] tx_vec();
    return {tb1, tb2, tmon, td, tci, ta, te};
  endfunction

  function automatic logic [31:0] rx_vec();
    return {rb1, rb2, rmon, rd, rci, ra, re};
  endfunction

  // behavioural reference: frame cycle 0..63, position = cycle/2
  bit m_lock, m_err, m_val;
  int m_cyc;
  logic [31:0] m_rx, m_work, m_sh;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lock = 0; m_err = 0; m_val = 0; m_cyc = 0;
      m_rx = '0; m_work = '0; m_sh = '0;
    end else begin
      automatic bit fend = m_lock && (m_cyc == 63);
      if (m_lock && (m_cyc % 2 == 1)) m_work[31 - m_cyc/2] = en[m_cyc/2] & rxd;
      m_val = fend;
      if (fend) m_rx = m_work;
      if (sync) begin
        if (m_lock && !fend) m_err = 1;
        m_lock = 1; m_cyc = 0; m_sh = tx_vec();
      end else if (m_lock) begin
        m_cyc = (m_cyc + 1) % 64;
        if (m_cyc == 0) m_sh = tx_vec();
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      automatic bit e_oe = m_lock && en[m_cyc/2];
      automatic logic e_txd = e_oe ? m_sh[31 - m_cyc/2] : 1'b1;
      chk("R5 txd_oe", {31'b0, txd_oe}, {31'b0, e_oe});
      chk("R5 txd", {31'b0, txd}, {31'b0, e_txd});
      chk("R4 rx_valid", {31'b0, rxv}, {31'b0, m_val});
      chk("R3 rx fields", rx_vec(), m_rx);
      chk("R8 sync_err", {31'b0, serr}, {31'b0, m_err});
    end
  end

  logic [31:0] tx_next;
  bit [31:0] cap;

  task automatic set_tx(input logic [31:0] v);
    {tb1, tb2, tmon, td, tci, ta, te} = v;
  endtask

  // drives ncyc cycles starting at the negedge of position 0
  task automatic run_frame(input logic [31:0] rxpat, input int sync_at,
                           input int chg_at, input int ncyc);
    logic prev;
    prev = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c % 2 == 1) begin
        cap[31 - c/2] = txd;
        if (en == 32'hFFFF_FFFF) chk("R1 bit spans two cycles", {31'b0, txd}, {31'b0, prev});
      end
      prev = txd;
      rxd  = rxpat[31 - c/2];
      sync = (c == sync_at);
      if (c == chg_at) set_tx(tx_next);
    end
  endtask

  task automatic frame_end_chk(input logic [31:0] exp, input string req);
    @(posedge clk); #2;
    chk({req, " strobe"}, {31'b0, rxv}, 32'd1);
    chk({req, " fields"}, rx_vec(), exp);
  endtask

  initial begin
    logic [31:0] pat, v1, v2;
    repeat (3) @(negedge clk);
    chk("R10 oe", {31'b0, txd_oe}, 32'd0);
    chk("R10 txd", {31'b0, txd}, 32'd1);
    chk("R10 valid+err", {30'b0, rxv, serr}, 32'd0);
    chk("R10 rx", rx_vec(), 32'd0);
    rst_n = 1'b1;
    en = 32'hFFFF_FFFF;
    v1 = 32'hA5C3_3C5B;
    set_tx(v1);
    repeat (20) begin
      @(posedge clk); #2;
      chk("R7 no drive before sync", {30'b0, txd_oe, rxv}, 32'd0);
    end
    @(negedge clk); sync = 1'b1;

    // all positions enabled, known patterns
    pat = 32'h1234_5679;
    run_frame(pat, 63, -1, 64);
    chk("R2 tx order", cap, v1);
    frame_end_chk(pat, "R2 rx order");

    // tx change mid-frame is deferred
    v2 = 32'h0F1E_2D3C;
    tx_next = v2;
    run_frame(~pat, 63, 10, 64);
    chk("R6 old fields kept", cap, v1);
    frame_end_chk(~pat, "R3 rx");
    run_frame(pat, 63, -1, 64);
    chk("R6 new fields at next frame", cap, v2);
    frame_end_chk(pat, "R3 rx");

    // signaling positions only
    en = 32'h0300_0000;
    run_frame(32'hFFFF_FFFF, 63, -1, 64);
    frame_end_chk(32'h0000_00C0, "R3 D-only map");
    // E position only
    en = 32'h8000_0000;
    run_frame(32'hFFFF_FFFF, -1, -1, 64);
    frame_end_chk(32'h0000_0001, "R3 E-only map");

    // random maps, free-running frames
    for (int f = 0; f < 6; f++) begin
      en = $urandom;
      pat = $urandom;
      tx_next = $urandom;
      run_frame(pat, (f % 2 == 0) ? 63 : -1, 30, 64);
      frame_end_chk(pat & rev32(en), "R9 free-run frame");
    end
    chk("R9 no error at boundary", {31'b0, serr}, 32'd0);

    // misplaced sync
    en = 32'hFFFF_FFFF;
    run_frame(32'hDEAD_BEEF, 20, -1, 21);
    @(posedge clk); #2;
    chk("R8 err set", {31'b0, serr}, 32'd1);
    chk("R8 no strobe", {31'b0, rxv}, 32'd0);
    pat = 32'h8421_1248;
    run_frame(pat, 63, -1, 64);
    frame_end_chk(pat, "R8 restarted frame");
    repeat (70) @(negedge clk);
    chk("R8 err sticky", {31'b0, serr}, 32'd1);

    rst_n = 1'b0;
    #1;
    chk("R10 err cleared", {31'b0, serr}, 32'd0);
    chk("R10 oe in reset", {31'b0, txd_oe}, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule